// File: doc/BRIEF.md
# Multi-Source Reset Controller with Pin Stretcher

This block gathers reset requests from inside the chip (independent watchdog, window watchdog, software, debug port and undefined-instruction detection) together with the power-good indication and a shared active-low reset pin. The pin output can only pull low. When any internal request is seen, however brief, the pin is pulled low for a guaranteed minimum time. The pin level is then synchronised and glitch-filtered, so a reset from inside the chip and one from outside it follow the same path to the system reset.

Each internal request is caught by its own asynchronously set flop, so a pulse shorter than one clock period is still captured. A reload counter sized from the clock frequency and the minimum pulse time in microseconds then holds the pin low. Software can turn the pin into a general-purpose output. In that mode the pin follows a level input and the pin no longer feeds the system reset, but internal requests still reset the system. A sticky cause register records every source seen since it was last cleared. Only loss of power-good resets it.

Top module: `rst_ctrl`

## Requirements
- R1: While general-purpose mode is off, an active request on any of the five internal request inputs asserts pin_drive_low in the same cycle, including a request that is high for less than one clock period between two edges.
- R2: A single short internal request keeps pin_drive_low high for exactly STRETCH = CLK_HZ/1e6*PULSE_US clock cycles, counted from the first rising clock edge after the request.
- R3: A new internal request during a stretch reloads the counter, so the pin stays low for STRETCH cycles after the first edge that follows the new request.
- R4: While pwr_good is low, pin_drive_low and sys_rst are both 1 and cause equals 7'b0000010. After pwr_good rises, the pin stays driven for another STRETCH-1 sampled cycles.
- R5: sys_rst follows the synchronised pin only after the pin has held a new level for FILT_N consecutive clock edges. A low lasting FILT_N-1 edges is ignored. The filtered output changes on the edge FILT_N+2 after the pin changes, because of the two synchroniser stages.
- R6: sys_rst is 1 throughout every internal stretch and becomes 0 once the stretch has ended and the filtered pin is high again.
- R7: When gpo_mode is 1, pin_drive_low equals the inverse of gpo_level. Internal requests then do not drive the pin but still assert sys_rst. A low pin does not assert sys_rst.
- R8: Cause bit positions are: 0 external pin, 1 power-on, 2 independent watchdog, 3 window watchdog, 4 software, 5 debug port, 6 undefined instruction. The external bit is set only when the filter detects a low while no internal stretch is active and gpo_mode is 0.
- R9: A cause_clr sampled high at a clock edge clears the cause register. A source that is recorded on the same edge wins, so only that source's bit remains.
- R10: Cause bits accumulate across resets that are not power-on resets, and they never fall without cause_clr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pwr_good | input | 1 | Supply valid; low is the power-on reset (asynchronous) |
| iwdg_req | input | 1 | Independent watchdog reset request |
| wwdg_req | input | 1 | Window watchdog reset request |
| sw_req | input | 1 | Software reset request |
| dbg_req | input | 1 | Debug port reset request |
| illop_req | input | 1 | Undefined instruction reset request |
| pin_in | input | 1 | Level read back from the reset pin |
| gpo_mode | input | 1 | Pin used as general-purpose output |
| gpo_level | input | 1 | Pin level requested in general-purpose mode |
| cause_clr | input | 1 | Clears the cause register |
| pin_drive_low | output | 1 | Enable of the open-drain pull-down on the pin |
| sys_rst | output | 1 | System reset, active high |
| cause | output | 7 | Sticky reset-cause flags |

## Verification
Two actions can fall on the same clock edge: a software clear of the cause register, and the recording of a new source, either a short internal request or a retrigger that reloads a running stretch. The bench raises cause_clr and fires a sub-cycle request inside that same period, then expects only the new source's bit to survive. It also fires a second request partway through a stretch and expects the total pin-low count to equal the offset plus one full STRETCH. Random sequences of short requests, mixed with clears, are checked against a cause value and pulse widths that bench functions predict.

// File: rtl/rst_ctrl.sv
module rst_ctrl #(
  parameter int CLK_HZ   = 50_000_000,
  parameter int PULSE_US = 20,
  parameter int FILT_N   = 4
) (
  input  logic       clk,
  input  logic       pwr_good,
  input  logic       iwdg_req,
  input  logic       wwdg_req,
  input  logic       sw_req,
  input  logic       dbg_req,
  input  logic       illop_req,
  input  logic       pin_in,
  input  logic       gpo_mode,
  input  logic       gpo_level,
  input  logic       cause_clr,
  output logic       pin_drive_low,
  output logic       sys_rst,
  output logic [6:0] cause
);
  localparam int STRETCH = (CLK_HZ / 1_000_000) * PULSE_US;
  localparam int CW = $clog2(STRETCH + 1);
  localparam int FW = $clog2(FILT_N + 1);

  logic [4:0] req, pend;
  logic [CW-1:0] cnt;
  logic [1:0] sy;
  logic sync_low, filt_low, stretch, ext_set;
  logic [FW-1:0] fcnt;

  assign req = {illop_req, dbg_req, sw_req, wwdg_req, iwdg_req};

  for (genvar g = 0; g < 5; g++) begin : g_catch
    logic p;
    always_ff @(posedge clk or posedge req[g] or negedge pwr_good)
      if (!pwr_good) p <= 1'b0;
      else if (req[g]) p <= 1'b1;
      else p <= 1'b0;
    assign pend[g] = p;
  end

  always_ff @(posedge clk or negedge pwr_good)
    if (!pwr_good) cnt <= CW'(STRETCH);
    else if (|pend) cnt <= CW'(STRETCH);
    else if (cnt != '0) cnt <= cnt - 1'b1;

  assign stretch = (|pend) | (cnt != '0);
  assign pin_drive_low = !pwr_good | (gpo_mode ? !gpo_level : stretch);

  always_ff @(posedge clk or negedge pwr_good)
    if (!pwr_good) sy <= 2'b00;
    else sy <= {sy[0], pin_in};
  assign sync_low = !sy[1];

  always_ff @(posedge clk or negedge pwr_good)
    if (!pwr_good) begin
      filt_low <= 1'b1;
      fcnt <= '0;
    end else if (sync_low != filt_low) begin
      if (fcnt == FW'(FILT_N - 1)) begin
        filt_low <= sync_low;
        fcnt <= '0;
      end else fcnt <= fcnt + 1'b1;
    end else fcnt <= '0;

  assign ext_set = sync_low && !filt_low && (fcnt == FW'(FILT_N - 1)) && !gpo_mode && !stretch;
  assign sys_rst = !pwr_good | stretch | (filt_low & !gpo_mode);

  always_ff @(posedge clk or negedge pwr_good)
    if (!pwr_good) cause <= 7'b0000010;
    else cause <= (cause_clr ? 7'b0 : cause) | {pend, 1'b0, ext_set};

  logic [CW:0] lrun;
  logic [FW:0] lo_run, hi_run;
  always_ff @(posedge clk or negedge pwr_good)
    if (!pwr_good) begin
      lrun <= '0;
      lo_run <= '0;
      hi_run <= '0;
    end else begin
      lrun <= (pin_drive_low && !gpo_mode) ? ((lrun == '1) ? lrun : lrun + 1'b1) : '0;
      lo_run <= sync_low ? ((lo_run == '1) ? lo_run : lo_run + 1'b1) : '0;
      hi_run <= !sync_low ? ((hi_run == '1) ? hi_run : hi_run + 1'b1) : '0;
    end

  a_r1_req_pulls_pin: assert property (@(posedge clk) disable iff (!pwr_good)
    ((|req) && !gpo_mode) |-> pin_drive_low);
  a_r2_min_width: assert property (@(posedge clk) disable iff (!pwr_good)
    ($fell(pin_drive_low) && !gpo_mode && !$past(gpo_mode)) |-> (lrun >= (CW+1)'(STRETCH)));
  a_r5_low_after_run: assert property (@(posedge clk) disable iff (!pwr_good)
    $rose(filt_low) |-> (lo_run >= (FW+1)'(FILT_N)));
  a_r5_high_after_run: assert property (@(posedge clk) disable iff (!pwr_good)
    $fell(filt_low) |-> (hi_run >= (FW+1)'(FILT_N)));
  a_r7_gpo_still_resets: assert property (@(posedge clk) disable iff (!pwr_good)
    (gpo_mode && (|req)) |-> sys_rst);
  a_r10_sticky: assert property (@(posedge clk) disable iff (!pwr_good)
    !cause_clr |=> ((cause & $past(cause)) == $past(cause)));
endmodule

// File: tb/rst_ctrl_tb.sv
module rst_ctrl_tb;
  localparam int STRETCH = 1000;
  localparam int FN = 4;

  logic clk = 0, pwr_good = 0, gpo_mode = 0, gpo_level = 1, cause_clr = 0, ext_low = 0;
  logic [4:0] rq = '0;
  logic pin_drive_low, sys_rst, pin_in;
  logic [6:0] cause;
  int errors = 0, checks = 0, cyc = 0;
  logic [6:0] exp_cause;

  always #10 clk = ~clk;
  assign pin_in = !(pin_drive_low | ext_low);

  rst_ctrl u_dut (
    .clk(clk), .pwr_good(pwr_good), .iwdg_req(rq[0]), .wwdg_req(rq[1]), .sw_req(rq[2]),
    .dbg_req(rq[3]), .illop_req(rq[4]), .pin_in(pin_in), .gpo_mode(gpo_mode),
    .gpo_level(gpo_level), .cause_clr(cause_clr), .pin_drive_low(pin_drive_low),
    .sys_rst(sys_rst), .cause(cause)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [6:0] src_bit(int s);
    return 7'(1) << (s + 2);
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic fire(int s, int ns);
    #2 rq[s] = 1'b1;
    #(ns) rq[s] = 1'b0;
  endtask

  task automatic count_low(inout int n);
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (pin_drive_low) n++; else break;
    end
  endtask

  task automatic settle();
    repeat (FN + 6) @(negedge clk);
  endtask

  task automatic clear_cause();
    @(negedge clk); #1 cause_clr = 1;
    @(negedge clk); cause_clr = 0;
    exp_cause = '0;
  endtask

  initial begin
    int n;
    repeat (4) @(negedge clk);
    check("R4 drive during power-on", pin_drive_low, 1);
    check("R4 sys_rst during power-on", sys_rst, 1);
    check("R4 cause after power-on", cause, 2);
    #1 pwr_good = 1;
    n = 0; count_low(n);
    check("R4 post power-on stretch", n, STRETCH - 1);
    settle();
    check("R6 sys_rst released", sys_rst, 0);
    check("R10 power-on bit kept", cause, 2);
    clear_cause();
    check("R9 cleared", cause, 0);

    for (int s = 0; s < 5; s++) begin
      @(negedge clk);
      fork fire(s, 5); join_none
      #3 check("R1 sub-cycle request drives pin", pin_drive_low, 1);
      n = 0; count_low(n);
      check("R2 stretch width", n, STRETCH);
      check("R8 cause bit position", cause, src_bit(s));
      settle();
      clear_cause();
    end

    @(negedge clk); fire(1, 4);
    repeat (3) @(negedge clk);
    check("R6 sys_rst during stretch", sys_rst, 1);
    n = 3; count_low(n); settle();
    @(negedge clk); fire(4, 4);
    n = 0; count_low(n); settle();
    check("R10 causes accumulate", cause, src_bit(1) | src_bit(4));
    clear_cause();

    @(negedge clk); fire(0, 6);
    n = 0;
    repeat (300) begin @(negedge clk); n++; end
    fire(2, 6);
    count_low(n);
    check("R3 retrigger total width", n, 300 + STRETCH);
    settle();
    clear_cause();

    @(negedge clk); #1 ext_low = 1;
    repeat (FN - 1) @(negedge clk);
    ext_low = 0;
    n = 0;
    repeat (10) begin @(negedge clk); n += sys_rst; end
    check("R5 short pin low ignored", n, 0);
    check("R8 no cause from glitch", cause, 0);

    @(negedge clk); #1 ext_low = 1;
    repeat (FN + 1) @(posedge clk);
    @(negedge clk); check("R5 not yet asserted", sys_rst, 0);
    @(negedge clk); check("R5 asserted after filter", sys_rst, 1);
    repeat (5) @(negedge clk);
    #1 ext_low = 0;
    repeat (FN + 1) @(posedge clk);
    @(negedge clk); check("R5 still held", sys_rst, 1);
    @(negedge clk); check("R5 released after filter", sys_rst, 0);
    check("R8 external bit", cause, 1);

    @(negedge clk); #1 cause_clr = 1;
    fire(3, 5);
    @(negedge clk); cause_clr = 0;
    check("R9 set wins over clear", cause, src_bit(3));
    n = 0; count_low(n); settle();
    clear_cause();

    @(negedge clk); gpo_mode = 1; gpo_level = 1;
    @(negedge clk); check("R7 gpo high", pin_drive_low, 0);
    gpo_level = 0;
    @(negedge clk); check("R7 gpo low", pin_drive_low, 1);
    check("R7 low pin no reset", sys_rst, 0);
    gpo_level = 1;
    @(negedge clk);
    fork fire(0, 5); join_none
    #3 check("R7 request ignored by pin", pin_drive_low, 0);
    check("R7 request still resets", sys_rst, 1);
    repeat (STRETCH + 5) @(negedge clk);
    check("R7 stretch over", sys_rst, 0);
    #1 ext_low = 1;
    repeat (FN + 4) @(negedge clk);
    check("R7 external pin ignored", sys_rst, 0);
    ext_low = 0;
    settle();
    gpo_mode = 0;
    settle();
    check("R8 cause in gpo mode", cause, src_bit(0));
    clear_cause();

    void'($urandom(32'd1234));
    for (int it = 0; it < 10; it++) begin
      int s, w, gap;
      s = int'($urandom % 5);
      w = 1 + int'($urandom % 7);
      gap = int'($urandom % 20);
      if ($urandom % 3 == 0) clear_cause();
      repeat (gap) @(negedge clk);
      fire(s, w);
      exp_cause = exp_cause | src_bit(s);
      n = 0; count_low(n);
      check("R2 random width", n, STRETCH);
      settle();
      check("R10 random cause", cause, exp_cause);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule